// File: doc/BRIEF.md
# Parallel Printer Port Controller

This block sits on a simple register read/write bus and presents a byte-wide printer port through three registers: an outgoing data byte, a printer status byte and a port control byte. It does not drive physical pins with timing. It keeps its own model of the printer's handshake instead. Control writes release the busy flag and push the held data byte out on a byte stream. Successive status reads walk the acknowledge and busy flags through an acknowledge sequence and retire a pending interrupt.

A level interrupt output follows an internal pending flag. A control write raises this flag when interrupts are already enabled. A data write or the final step of the acknowledge sequence lowers it. When software sets the direction bit, a data-register read returns the byte on the `pin_din` input instead of the last byte written. Offset 0 holds data, offset 1 holds status and offset 2 holds control. Every other offset in the address window reads as all ones and ignores writes.

Reads are combinational. `bus_rdata` shows the addressed register in the same cycle that `bus_rd` is high, and any side effect of the read takes place at the closing clock edge. The bus must not raise `bus_wr` and `bus_rd` together.

Top module: `lpt_port_ctrl`

## Requirements
- R1: After reset, status reads 0xD9, control reads 0x0C, a data read returns 0x00, and `irq` and `tx_valid` are low.
- R2: A control read (offset 2) returns the last value written there. Offsets 3 to 7 read 0xFF, and a write to them changes no register.
- R3: When control bit 5 (direction, 0x20) is 1, a data read (offset 0) returns `pin_din`. Otherwise it returns the last byte written to offset 0.
- R4: A control write with bit 2 (init, 0x04) clear loads status with 0xD8. This clears the timeout bit, bit 0.
- R5: A control write with init and bit 3 (select, 0x08) both set and bit 0 (strobe, 0x01) set clears status bit 7 (busy, 0x80).
- R6: The write in R5 emits the data byte on `tx_byte` with `tx_valid` high for exactly one cycle, following the write edge. It does so only when the stored control value before the write had strobe clear. Any other control write emits nothing.
- R7: A control write with init and select set and strobe clear raises `irq` when the stored control value before the write had bit 4 (interrupt enable, 0x10) set.
- R8: A status read (offset 1) returns the current status. The read steps the acknowledge sequence only while busy is clear and stored strobe is clear. If bit 6 (ack, 0x40) is set, the step clears it. Otherwise the step sets ack and busy and lowers `irq`.
- R9: A status read with busy set or stored strobe set leaves status and `irq` unchanged.
- R10: A write to the data register lowers `irq`.
- R11: Status bit 0 (timeout) is set only by reset, and once it is cleared it stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (3) | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| pin_din | input | 8 | Byte returned by data reads in input direction |
| tx_valid | output | 1 | One-cycle pulse marking an emitted byte |
| tx_byte | output | 8 | Emitted byte |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the "previous value" rules. An emission or interrupt keyed on the newly written control byte instead of the stored one would emit twice on repeated strobe writes, or raise the interrupt on the very write that enables it. It walks the acknowledge sequence through both steps and checks that the returned status is the value from before the step. An off-by-one there would show 0x19 where 0x59 is expected. It also checks that reads gated by busy or by strobe change nothing, that the direction bit switches the data source without touching the held byte, and that writes to undefined offsets leave control intact.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
   // register offsets; software decodes these
   localparam int unsigned OFS_DATA = 0;
   localparam int unsigned OFS_STAT = 1;
   localparam int unsigned OFS_CTRL = 2;
   localparam int unsigned NUM_REGS = 3;

   // status bit positions
   localparam int unsigned ST_BUSY_N = 7;
   localparam int unsigned ST_ACK    = 6;
   localparam int unsigned ST_PAPER  = 5;
   localparam int unsigned ST_ONLINE = 4;
   localparam int unsigned ST_ERR_N  = 3;
   localparam int unsigned ST_TMO    = 0;

   // control bit positions
   localparam int unsigned CT_DIR    = 5;
   localparam int unsigned CT_IEN    = 4;
   localparam int unsigned CT_SEL    = 3;
   localparam int unsigned CT_INIT   = 2;
   localparam int unsigned CT_ALF    = 1;
   localparam int unsigned CT_STB    = 0;

   localparam logic [7:0] STAT_RST  = 8'hD9;
   localparam logic [7:0] STAT_INIT = 8'hD8;
   localparam logic [7:0] CTRL_RST  = 8'h0C;

   typedef struct packed {
      logic wr_data;
      logic wr_ctrl;
      logic rd_stat;
   } lpt_acc_t;
endpackage

// File: rtl/lpt_addr_dec.sv
module lpt_addr_dec
   import lpt_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                wr,
   input  logic                rd,
   output logic [NUM_REGS-1:0] hit,
   output logic                undef,
   output lpt_acc_t            acc
);
   if (ADDR_W < 2) begin : g_bad_aw
      $error("lpt_addr_dec: ADDR_W must cover three registers");
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      assign hit[i] = (addr == ADDR_W'(i));
   end

   assign undef = ~|hit;

   always_comb begin
      acc.wr_data = wr & hit[OFS_DATA];
      acc.wr_ctrl = wr & hit[OFS_CTRL];
      acc.rd_stat = rd & ~wr & hit[OFS_STAT];
   end
endmodule

// File: rtl/lpt_ctrl_hs.sv
module lpt_ctrl_hs
   import lpt_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lpt_acc_t          acc,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] stat_q,
   output logic              irq_q,
   output logic              emit
);
   if (DATA_W != 8) begin : g_bad_dw
      $error("lpt_ctrl_hs: register map is byte wide");
   end

   logic link_up;     // init and select both set in the written value
   logic ack_step;    // status read allowed to advance the sequence

   assign link_up  = wdata[CT_INIT] & wdata[CT_SEL];
   assign emit     = acc.wr_ctrl & link_up & wdata[CT_STB] & ~ctrl_q[CT_STB];
   assign ack_step = acc.rd_stat & ~stat_q[ST_BUSY_N] & ~ctrl_q[CT_STB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         stat_q <= STAT_RST;
         irq_q  <= 1'b0;
      end else begin
         if (acc.wr_data) irq_q <= 1'b0;
         if (acc.wr_ctrl) begin
            ctrl_q <= wdata;
            if (!wdata[CT_INIT]) begin
               stat_q <= STAT_INIT;
            end else if (wdata[CT_SEL]) begin
               if (wdata[CT_STB]) stat_q[ST_BUSY_N] <= 1'b0;
               else if (ctrl_q[CT_IEN]) irq_q <= 1'b1;
            end
         end
         if (ack_step) begin
            if (stat_q[ST_ACK]) begin
               stat_q[ST_ACK] <= 1'b0;
            end else begin
               stat_q[ST_ACK]    <= 1'b1;
               stat_q[ST_BUSY_N] <= 1'b1;
               irq_q             <= 1'b0;
            end
         end
      end
   end

   // R4
   init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.wr_ctrl && !wdata[CT_INIT]) |=> (stat_q == STAT_INIT));
   // R7
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.wr_ctrl && wdata[CT_INIT] && wdata[CT_SEL] && !wdata[CT_STB]
       && ctrl_q[CT_IEN]) |=> irq_q);
   // R8
   ack_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd_stat && !stat_q[ST_BUSY_N] && !ctrl_q[CT_STB] && !stat_q[ST_ACK])
      |=> (!irq_q && stat_q[ST_BUSY_N] && stat_q[ST_ACK]));
   // R9
   gated_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc.rd_stat && (stat_q[ST_BUSY_N] || ctrl_q[CT_STB]))
      |=> ($stable(stat_q) && $stable(irq_q)));
   // R11
   tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_q[ST_TMO] |=> !stat_q[ST_TMO]);
endmodule

// File: rtl/lpt_tx_emit.sv
module lpt_tx_emit
   import lpt_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lpt_acc_t          acc,
   input  logic [DATA_W-1:0] wdata,
   input  logic              emit,
   output logic [DATA_W-1:0] data_q,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_byte
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         tx_valid <= 1'b0;
         tx_byte  <= '0;
      end else begin
         if (acc.wr_data) data_q <= wdata;
         tx_valid <= emit;
         if (emit) tx_byte <= data_q;
      end
   end

   // R6
   tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid);
   // R6
   tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> $past(acc.wr_ctrl && wdata[CT_STB]));
endmodule

// File: rtl/lpt_port_ctrl.sv
module lpt_port_ctrl
   import lpt_pkg::*;
#(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned DATA_W    = 8,
   parameter logic [7:0]  UNDEF_VAL = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] pin_din,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_byte,
   output logic              irq
);
   logic [NUM_REGS-1:0] hit;
   logic                undef;
   lpt_acc_t            acc;
   logic [DATA_W-1:0]   ctrl_q, stat_q, data_q;
   logic                emit;

   lpt_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .hit(hit), .undef(undef), .acc(acc)
   );

   lpt_ctrl_hs #(.DATA_W(DATA_W)) u_hs (
      .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(bus_wdata),
      .ctrl_q(ctrl_q), .stat_q(stat_q), .irq_q(irq), .emit(emit)
   );

   lpt_tx_emit #(.DATA_W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(bus_wdata),
      .emit(emit), .data_q(data_q), .tx_valid(tx_valid), .tx_byte(tx_byte)
   );

   always_comb begin
      bus_rdata = UNDEF_VAL;
      if (hit[OFS_DATA]) bus_rdata = ctrl_q[CT_DIR] ? pin_din : data_q;
      if (hit[OFS_STAT]) bus_rdata = stat_q;
      if (hit[OFS_CTRL]) bus_rdata = ctrl_q;
      if (undef)         bus_rdata = UNDEF_VAL;
   end

   // R2
   undef_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && undef) |=> ($stable(ctrl_q) && $stable(data_q)));
endmodule

// File: tb/lpt_port_ctrl_tb.sv
`timescale 1ns/1ps
module lpt_port_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, pin_din = 8'hA7;
   logic [7:0] bus_rdata, tx_byte;
   logic       tx_valid, irq;
   int         n_chk = 0, n_bad = 0, n_tx = 0;
   logic [7:0] rd_val;

   always #2 clk = ~clk;

   lpt_port_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_din(pin_din), .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
   );

   always @(negedge clk) if (rst_n && tx_valid) n_tx++;

   // vector: {is_wr, addr, value, expected read, expected irq after}
   localparam int NV = 23;
   localparam logic [20:0] VEC [0:NV-1] = '{
      {1'b0, 3'd1, 8'h00, 8'hD9, 1'b0},  // R9 busy set: no step
      {1'b0, 3'd2, 8'h00, 8'h0C, 1'b0},  // R2
      {1'b1, 3'd0, 8'h55, 8'h00, 1'b0},
      {1'b0, 3'd0, 8'h00, 8'h55, 1'b0},  // R3
      {1'b1, 3'd2, 8'h1C, 8'h00, 1'b0},  // R7 old enable clear
      {1'b1, 3'd2, 8'h1C, 8'h00, 1'b1},  // R7 old enable set
      {1'b1, 3'd2, 8'h1D, 8'h00, 1'b1},  // R5
      {1'b0, 3'd1, 8'h00, 8'h59, 1'b1},  // R9 strobe set: no step
      {1'b1, 3'd2, 8'h1C, 8'h00, 1'b1},
      {1'b0, 3'd1, 8'h00, 8'h59, 1'b1},  // R8 clears ack
      {1'b0, 3'd1, 8'h00, 8'h19, 1'b0},  // R8 sets ack, busy
      {1'b0, 3'd1, 8'h00, 8'hD9, 1'b0},  // R9
      {1'b1, 3'd2, 8'h3C, 8'h00, 1'b1},
      {1'b0, 3'd0, 8'h00, 8'hA7, 1'b1},  // R3 input direction
      {1'b1, 3'd0, 8'h33, 8'h00, 1'b0},  // R10
      {1'b0, 3'd0, 8'h00, 8'hA7, 1'b0},  // R3
      {1'b1, 3'd2, 8'h18, 8'h00, 1'b0},  // R4
      {1'b0, 3'd1, 8'h00, 8'hD8, 1'b0},  // R4 R11
      {1'b0, 3'd0, 8'h00, 8'h33, 1'b0},  // R3
      {1'b1, 3'd5, 8'hAA, 8'h00, 1'b0},
      {1'b0, 3'd5, 8'h00, 8'hFF, 1'b0},  // R2
      {1'b0, 3'd3, 8'h00, 8'hFF, 1'b0},  // R2
      {1'b0, 3'd2, 8'h00, 8'h18, 1'b0}   // R2 undefined write ignored
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // drive at negedge, sample read before the edge, return at next negedge
   task automatic bus_op(input logic wr, input logic [2:0] a, input logic [7:0] v,
                         output logic [7:0] r);
      bus_addr = a; bus_wdata = v; bus_wr = wr; bus_rd = ~wr;
      #1 r = bus_rdata;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1 irq", {7'd0, irq}, 8'h00);
      check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
      bus_op(1'b0, 3'd0, 8'h00, rd_val); check("R1 data", rd_val, 8'h00);
      bus_op(1'b0, 3'd2, 8'h00, rd_val); check("R1 ctrl", rd_val, 8'h0C);
      bus_op(1'b0, 3'd1, 8'h00, rd_val); check("R1 status", rd_val, 8'hD9);

      for (int i = 0; i < NV; i++) begin
         bus_op(VEC[i][20], VEC[i][19:17], VEC[i][16:9], rd_val);
         if (!VEC[i][20]) check($sformatf("R2/R3/R8/R9 vec%0d rdata", i), rd_val, VEC[i][8:1]);
         check($sformatf("R7/R8/R10 vec%0d irq", i), {7'd0, irq}, {7'd0, VEC[i][0]});
      end
      check("R6 one emission in table", n_tx[7:0], 8'd1);

      // R6 directed: emission timing and byte
      do_reset();
      bus_op(1'b1, 3'd0, 8'hC3, rd_val);
      bus_addr = 3'd2; bus_wdata = 8'h0D; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
      check("R6 tx_valid after edge", {7'd0, tx_valid}, 8'h01);
      check("R6 tx_byte", tx_byte, 8'hC3);
      @(negedge clk);
      check("R6 tx_valid one cycle", {7'd0, tx_valid}, 8'h00);
      bus_op(1'b0, 3'd1, 8'h00, rd_val); check("R5 busy cleared", rd_val, 8'h59);
      n_tx = 0;
      bus_op(1'b1, 3'd2, 8'h0D, rd_val);  // strobe already set
      bus_op(1'b1, 3'd2, 8'h0C, rd_val);
      bus_op(1'b1, 3'd2, 8'h05, rd_val);  // select clear
      bus_op(1'b0, 3'd1, 8'h00, rd_val); check("R5 no select no change", rd_val, 8'h59);
      bus_op(1'b1, 3'd2, 8'h0C, rd_val);
      bus_op(1'b1, 3'd2, 8'h09, rd_val);  // init clear, strobe set
      @(negedge clk);
      check("R6 no emission", n_tx[7:0], 8'd0);
      bus_op(1'b0, 3'd1, 8'h00, rd_val); check("R4 R11 init load", rd_val, 8'hD8);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule